// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a serial-bus slave on the standard two-wire protocol (I2C). It gives a host access to a 16-byte register window at memory addresses F0h to FFh. The lower eight bytes, F0h to F7h, hold configuration and reserved bytes. The upper eight, F8h to FFh, hold user bytes. The configuration bytes are driven out in parallel so that the rest of the chip can use them.

The host can write one byte, or read one byte at an address of its choice. After every write closed by a stop, the slave imitates the program time of a nonvolatile store: for a fixed number of system clocks it does not acknowledge its own address. A host polls on that NACK to learn when the store is ready.

The bus lines are brought into the system clock through two-flop synchronizers before any edge, start or stop is detected. The slave pulls SDA low through an open-drain enable; it never drives SDA high.

The controller is a single state machine with these states:
- S_IDLE: the bus is free.
- S_DEV: shift in the device-address byte.
- S_DEV_ACK: acknowledge the device address.
- S_MEM: shift in the memory address.
- S_MEM_ACK: acknowledge the memory address.
- S_WDATA: shift in the data byte.
- S_WDATA_ACK: acknowledge the data byte and store it.
- S_RDATA: shift out the data byte.
- S_RD_ACK: take the host's acknowledge bit.
- S_IGNORE: stay silent until the next start or stop.

It moves between them as follows:
- A start, from any state, leads to S_DEV.
- A stop, from any state, leads to S_IDLE.
- When a full device byte is in S_DEV, a match with a free store leads to S_DEV_ACK; any other case leads to S_IGNORE.
- From S_DEV_ACK, the R/W bit selects the next state: S_RDATA when it is 1, S_MEM when it is 0.
- S_MEM leads to S_MEM_ACK, and S_MEM_ACK leads to S_WDATA.
- S_WDATA leads to S_WDATA_ACK, and S_WDATA_ACK leads to S_IGNORE.
- S_RDATA leads to S_RD_ACK, and S_RD_ACK leads to S_IGNORE.

Each move other than a start or a stop is taken on a falling edge of SCL.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The 7-bit device address is binary 101000 followed by the value of `addr_sel`. The R/W bit is the LSB of the first byte, with 0 meaning write. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: A device address that does not match is not acknowledged. All later bytes up to the next start are neither acknowledged nor acted on.
- R3: A write is made up of a start, the device address with W, a memory address, one data byte and a stop. Each of the three bytes is acknowledged, and the data is stored at the memory address.
- R4: A read is made up of a start, the device address with W, the memory address, a repeated start, the device address with R and one data byte. The data byte returns the stored value MSB first.
- R5: After reset, F0h to F6h hold 21h, 43h, 65h, 77h, 00h, 08h and 00h, and F7h to FFh hold 00h. `cfg_o[8*k+7:8*k]` carries byte F0h+k for k = 0 to 7.
- R6: A write to F8h to FFh takes effect only when bit 0 of byte F5h is 1. Otherwise the write is still acknowledged but leaves the byte unchanged.
- R7: For `BUSY_CYC` system clocks after the stop that closes a write, the device address is not acknowledged. After that time it is acknowledged again.
- R8: Memory addresses outside F0h to FFh are acknowledged. Writes to them change nothing, and reads from them return 00h.
- R9: `sda_oe` changes only while SCL is low, so the slave's data and acknowledge bits change after a falling edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Selects the LSB of the device address |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| cfg_o | output | 64 | Configuration bytes F0h to F7h, with F0h in the low byte |

## Verification
Two events can meet in the same moment:
- The store's busy window running out.
- The decision on a device address that has just arrived.

The bench places an address byte right after the stop that closes a write, so that the decision lands well inside the window, and expects a NACK. It then sends the same address once the window has passed and expects an ACK.

A second pairing is a change of the protect bit followed at once by a write to a user byte. The bench judges this by reading the user byte back before and after bit 0 of F5h changes.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_MEM,
        S_MEM_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RD_ACK,
        S_IGNORE
    } slv_state_e;

    localparam logic [5:0] DEV_PREFIX = 6'b101000;
    localparam logic [3:0] WIN_HIGH   = 4'hF;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
    parameter int NREG     = 16,
    parameter int CFGN     = 8,
    parameter int PROT_IDX = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [7:0]              wdata,
    input  logic [$clog2(NREG)-1:0] raddr,
    output logic [7:0]              rdata,
    output logic [CFGN*8-1:0]       cfg_o
);
    localparam int AW = $clog2(NREG);

    logic [NREG*8-1:0] flat;
    logic              prot;

    function automatic logic [7:0] default_byte(input int idx);
        case (idx)
            0:       return 8'h21;
            1:       return 8'h43;
            2:       return 8'h65;
            3:       return 8'h77;
            5:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    assign prot = flat[PROT_IDX*8];

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        localparam bit IS_USER = (i >= CFGN);
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= default_byte(i);
            else if (we && waddr == AW'(i) && (!IS_USER || prot))
                q <= wdata;
        end
        assign flat[i*8 +: 8] = q;
    end

    assign rdata = flat[{raddr, 3'b000} +: 8];
    assign cfg_o = flat[CFGN*8-1:0];
endmodule

// File: rtl/wr_busy_timer.sv
module wr_busy_timer #(
    parameter int BUSY_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int W = $clog2(BUSY_CYC + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= W'(BUSY_CYC);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int BUSY_CYC = 600,
    parameter int NREG     = 16,
    parameter int CFGN     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_sel,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    output logic [CFGN*8-1:0] cfg_o
);
    localparam int AW = $clog2(NREG);

    slv_state_e state;
    logic [3:0] cnt;
    logic [7:0] sh, tx, ptr;
    logic       rw, wr_pend;
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       busy, full, in_win, we;
    logic [7:0] rdata, rd_byte;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_regbank #(.NREG(NREG), .CFGN(CFGN), .PROT_IDX(5)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr[AW-1:0]), .wdata(sh),
        .raddr(ptr[AW-1:0]), .rdata(rdata), .cfg_o(cfg_o)
    );

    wr_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(stop_det & wr_pend), .busy(busy)
    );

    assign full    = (cnt == 4'd8);
    assign in_win  = (ptr[7:4] == WIN_HIGH);
    assign rd_byte = in_win ? rdata : 8'h00;

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            wr_pend <= 1'b0;
        end else if (start_det) begin
            state <= S_DEV;
            cnt   <= '0;
        end else if (stop_det) begin
            state   <= S_IDLE;
            wr_pend <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_IGNORE: ;
                S_DEV, S_MEM, S_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && full) begin
                        cnt <= '0;
                        if (state == S_DEV) begin
                            if (sh[7:1] == {DEV_PREFIX, addr_sel} && !busy) begin
                                rw    <= sh[0];
                                state <= S_DEV_ACK;
                            end else begin
                                state <= S_IGNORE;
                            end
                        end else if (state == S_MEM) begin
                            ptr   <= sh;
                            state <= S_MEM_ACK;
                        end else begin
                            wr_pend <= 1'b1;
                            state   <= S_WDATA_ACK;
                        end
                    end
                end
                S_DEV_ACK: if (scl_fall) begin
                    if (rw) begin
                        tx    <= rd_byte;
                        state <= S_RDATA;
                    end else begin
                        state <= S_MEM;
                    end
                end
                S_MEM_ACK:   if (scl_fall) state <= S_WDATA;
                S_WDATA_ACK: if (scl_fall) state <= S_IGNORE;
                S_RDATA: begin
                    if (scl_rise)
                        cnt <= cnt + 4'd1;
                    else if (scl_fall) begin
                        if (full) begin
                            cnt   <= '0;
                            state <= S_RD_ACK;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                        end
                    end
                end
                S_RD_ACK: if (scl_fall) state <= S_IGNORE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        we     = (state == S_WDATA) && scl_fall && full && !start_det && !stop_det && in_win;
        sda_oe = 1'b0;
        unique case (state)
            S_DEV_ACK, S_MEM_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                           sda_oe = ~tx[7];
            default:                           sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_i2c_chk.sv
module cfg_i2c_chk
    import cfg_i2c_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input slv_state_e  state,
    input logic        busy,
    input logic        stop_det,
    input logic        scl_s,
    input logic        sda_oe,
    input logic [63:0] cfg_o
);
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R7
    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV_ACK) |-> !busy); // R7
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R9
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !sda_oe); // R2
    AST_CFG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(cfg_o)); // R3
endmodule

bind cfg_i2c_slave cfg_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .busy(busy),
    .stop_det(stop_det), .scl_s(scl_s), .sda_oe(sda_oe), .cfg_o(cfg_o)
);

// File: tb/sim_cfg_i2c_slave.sv
`timescale 1ns/1ps
module sim_cfg_i2c_slave;
    localparam int BUSY = 600;
    localparam int T    = 10;
    localparam int NV   = 15;
    // {write, mem address, write data, expected read data}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'hF0, 8'h00, 8'h21},   // R4 R5
        {1'b0, 8'hF3, 8'h00, 8'h77},   // R5
        {1'b0, 8'hF5, 8'h00, 8'h08},   // R5
        {1'b1, 8'hF8, 8'hAA, 8'h00},   // R6 protected
        {1'b0, 8'hF8, 8'h00, 8'h00},   // R6
        {1'b1, 8'hF1, 8'h5A, 8'h00},   // R3
        {1'b0, 8'hF1, 8'h00, 8'h5A},   // R3 R4
        {1'b1, 8'hF5, 8'h09, 8'h00},   // R6 unlock
        {1'b1, 8'hF8, 8'hAA, 8'h00},   // R6
        {1'b0, 8'hF8, 8'h00, 8'hAA},   // R6
        {1'b1, 8'h10, 8'h33, 8'h00},   // R8
        {1'b0, 8'h10, 8'h00, 8'h00},   // R8
        {1'b0, 8'h00, 8'h00, 8'h00},   // R8
        {1'b1, 8'hFF, 8'hC3, 8'h00},   // R3
        {1'b0, 8'hFF, 8'h00, 8'hC3}    // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [63:0] cfg_o;
    wire  sda_line = sda_m & ~sda_oe;

    int compared = 0;
    int mismatched = 0;
    int edge_bad = 0;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_i2c_slave #(.BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe), .cfg_o(cfg_o)
    );

    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl_m) edge_bad++;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(2*T);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(T);
            scl_m = 1'b1; tick(T);
            scl_m = 1'b0; tick(T);
        end
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T/2);
        ack = ~sda_line; tick(T/2);
        scl_m = 1'b0; tick(T);
    endtask

    task automatic get_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(T);
            scl_m = 1'b1; tick(T/2);
            b[i] = sda_line; tick(T/2);
            scl_m = 1'b0;
        end
        tick(T);
        sda_m = 1'b1; scl_m = 1'b1; tick(T);   // NACK
        scl_m = 1'b0; tick(T);
    endtask

    function automatic logic [7:0] dev(input logic sel, input logic r);
        return {6'b101000, sel, r};
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
        logic k1, k2, k3;
        bus_start;
        put_byte(dev(addr_sel, 1'b0), k1);
        put_byte(a, k2);
        put_byte(d, k3);
        bus_stop;
        chk(req, {k1, k2, k3}, 3'b111);
        tick(BUSY + 50);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic [2:0] acks);
        logic k1, k2, k3;
        bus_start;
        put_byte(dev(addr_sel, 1'b0), k1);
        put_byte(a, k2);
        bus_start;
        put_byte(dev(addr_sel, 1'b1), k3);
        get_byte(d);
        bus_stop;
        acks = {k1, k2, k3};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [2:0] acks;
        logic k;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R5 reset state
        chk("R5 reset cfg_o", cfg_o, 64'h0000_0800_7765_4321);
        chk("R5 reset sda_oe", {63'd0, sda_oe}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][24]) begin
                do_write(VEC[v][23:16], VEC[v][15:8], "R3 write acks");
            end else begin
                do_read(VEC[v][23:16], d, acks);
                chk("R4 read acks", {61'd0, acks}, 64'd7);
                chk("R4 R6 R8 read data", {56'd0, d}, {56'd0, VEC[v][7:0]});
            end
        end
        chk("R3 cfg_o after writes", cfg_o, 64'h0000_0900_7765_5A21);

        // R7: address right after a write stop is refused, then accepted
        bus_start;
        put_byte(dev(addr_sel, 1'b0), k);
        put_byte(8'hF2, k);
        put_byte(8'h11, k);
        bus_stop;
        bus_start;
        put_byte(dev(addr_sel, 1'b0), k);
        chk("R7 NACK while busy", {63'd0, k}, 64'd0);
        bus_stop;
        tick(BUSY + 50);
        bus_start;
        put_byte(dev(addr_sel, 1'b0), k);
        chk("R7 ACK after busy", {63'd0, k}, 64'd1);
        bus_stop;
        tick(BUSY + 50);

        // R2: wrong address refused and the following bytes ignored
        bus_start;
        put_byte(dev(1'b1, 1'b0), k);
        chk("R2 address NACK", {63'd0, k}, 64'd0);
        put_byte(8'hF1, k);
        chk("R2 later byte NACK", {63'd0, k}, 64'd0);
        put_byte(8'h00, k);
        bus_stop;
        tick(BUSY + 50);
        do_read(8'hF1, d, acks);
        chk("R2 F1 unchanged", {56'd0, d}, 64'h5A);

        // R1: address select pin moves the device address
        addr_sel = 1'b1;
        tick(5);
        do_read(8'hF0, d, acks);
        chk("R1 acks with addr_sel=1", {61'd0, acks}, 64'd7);
        chk("R1 data with addr_sel=1", {56'd0, d}, 64'h21);
        chk("R2 F2 kept via cfg_o", {56'd0, cfg_o[23:16]}, 64'h11);

        chk("R9 sda_oe changes only with SCL low", edge_bad, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule